// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves 36-bit words from a write clock domain to an independent read clock domain through a storage array with a depth set by a parameter. The write side accepts a word on each write-clock edge where the write enable is high and the FIFO is not full. The read side accepts a read on each read-clock edge where the read enable is high, the active-low chip select is low and data is available. Write and read positions cross between the domains as Gray-coded values, each passing through two flip-flops. Full is computed on the write side and empty on the read side.

Two straps and two offsets are sampled while the active-low master reset is held. They stay fixed until the next reset. The first strap picks the read style. In the registered style, a word reaches the output one read edge after an accepted read. In the look-ahead style, the head word is already on the output before any read, held in an extra staging register that adds one word of capacity. The second strap picks how the two active-low threshold flags are timed. In registered timing, each flag lives in one clock domain. In direct timing, each flag follows the live write and read positions, so a write edge and a read edge can each move it at once.

A load input decides whether the two offsets come from their input pins or from a parameter default.

Top module: `dcf_fifo36`

## Requirements
- R1: While master reset is low and after it is released, empty is 1, full is 0, the almost-empty flag `pae_n` is 0 and the almost-full flag `paf_n` is 1.
- R2: Words leave in the order they were accepted. In the registered style, `rd_data` takes the head word at the read edge that accepts a read.
- R3: Full is 1 when the FIFO holds D words in the registered style, or D+1 words in the look-ahead style, where D = 2^AW. A write while full changes nothing.
- R4: A read needs `rd_en`=1 and `rd_cs_n`=0. A read while empty, or one made with `rd_cs_n`=1, removes no word and leaves `rd_data` unchanged. Empty is 1 exactly when the FIFO holds no word.
- R5: In the look-ahead style (`fwft_sel`=1 at reset), the first written word appears on `rd_data` and empty goes to 0 without any read request.
- R6: `paf_n` is 0 while occupancy is at least Dt-m and 1 below it. Dt is D in the registered style and D+1 in the look-ahead style, and m is the almost-full offset.
- R7: `pae_n` is 0 while occupancy is at most n in the registered style, or at most n+1 in the look-ahead style, and 1 above it. n is the almost-empty offset.
- R8: With `ofs_load`=1 at reset, m and n are taken from `paf_off` and `pae_off`. With `ofs_load`=0, both equal the parameter DEF_OFF. Later changes on these pins have no effect.
- R9: With `flag_async_sel`=1 at reset, a write edge can drive `paf_n` low and `pae_n` high, and a read edge can drive `paf_n` high and `pae_n` low, each visible before the next edge of either clock. With `flag_async_sel`=0, `pae_n` rising and `paf_n` rising show up only several edges later, after the opposite position has been synchronised.
- R10: `fwft_sel` and `flag_async_sel` are taken only while master reset is low. Changing them afterwards does not change the behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Read-style strap: 1 selects look-ahead, 0 selects registered |
| flag_async_sel | input | 1 | Flag-timing strap: 1 selects direct timing, 0 selects registered timing |
| ofs_load | input | 1 | 1 takes the offsets from the pins during reset, 0 uses DEF_OFF |
| paf_off | input | AW+1 | Almost-full offset m |
| pae_off | input | AW+1 | Almost-empty offset n |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read request |
| rd_cs_n | input | 1 | Read chip select, active low |
| rd_data | output | 36 | Read word |
| full | output | 1 | No room for another word (write domain) |
| empty | output | 1 | No word available (read domain) |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
The bench runs three reset configurations. The first is registered style with registered flags and pin offsets. The second is look-ahead style with registered flags and default offsets. The third is registered style with direct flags. In each, the FIFO is filled one word at a time to overflow and then drained to underflow, with every flag checked against the occupancy after it settles. This sweep separates an off-by-one threshold from the look-ahead capacity shift. Flags are also sampled half a clock after the edge that crosses a threshold, which separates direct timing from registered timing. Reads made with chip select high or while empty, and strap and offset pins flipped after reset, show whether state is held or corrupted: the scoreboard order would break, or the thresholds would move.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  typedef struct packed {
    logic fwft;
    logic async_flags;
  } dcf_mode_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // almost-full when occupancy + m reaches the usable depth
  function automatic logic paf_hit(input logic [31:0] occ, input logic [31:0] depth,
                                   input logic fwft, input logic [31:0] off);
    return (occ + off) >= (depth + {31'b0, fwft});
  endfunction

  // almost-empty while occupancy stays at or below n (n+1 with staging)
  function automatic logic pae_hit(input logic [31:0] occ, input logic fwft,
                                   input logic [31:0] off);
    return occ <= (off + {31'b0, fwft});
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DEF_OFF = 2
) (
  input  logic          wr_clk,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          async_sel,
  input  logic          ofs_load,
  input  logic [AW:0]   paf_off,
  input  logic          wr_en,
  input  logic [AW:0]   rsync_g,
  input  logic [AW:0]   usync_g,
  output logic          wr_push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wptr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          paf_low_s,
  output dcf_mode_t     mode_w,
  output logic [AW:0]   m_q
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [AW:0] rbin_s, ubin_s, wptr_nx;

  assign rbin_s  = PW'(gray2bin(32'(rsync_g)));
  assign ubin_s  = PW'(gray2bin(32'(usync_g)));
  assign full    = ((wptr - rbin_s) == PW'(DEPTH));
  assign wr_push = wr_en & ~full;
  assign wptr_nx = wptr + PW'(wr_push);
  assign waddr   = wptr[AW-1:0];

  // straps and offset captured only while reset is held
  always_ff @(posedge wr_clk) begin
    if (!mrst_n) begin
      mode_w.fwft        <= fwft_sel;
      mode_w.async_flags <= async_sel;
      m_q                <= ofs_load ? paf_off : PW'(DEF_OFF);
    end
  end

  always_ff @(posedge wr_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      wptr      <= '0;
      wgray     <= '0;
      paf_low_s <= 1'b0;
    end else begin
      wptr      <= wptr_nx;
      wgray     <= PW'(bin2gray(32'(wptr_nx)));
      paf_low_s <= paf_hit(32'(wptr_nx - ubin_s), 32'(DEPTH), mode_w.fwft, 32'(m_q));
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 36,
  parameter int DEF_OFF = 2
) (
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          async_sel,
  input  logic          ofs_load,
  input  logic [AW:0]   pae_off,
  input  logic          rd_en,
  input  logic          rd_cs_n,
  input  logic [AW:0]   wsync_g,
  input  logic [DW-1:0] ram_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   ugray,
  output logic [AW:0]   uptr,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          pae_low_s,
  output dcf_mode_t     mode_r,
  output logic [AW:0]   n_q
);
  localparam int PW = AW + 1;

  logic [AW:0] rptr, wbin_s, rptr_nx, uptr_nx;
  logic        valid, ram_empty, rd_req, take, load_fw, ram_pop;

  assign wbin_s    = PW'(gray2bin(32'(wsync_g)));
  assign ram_empty = (rptr == wbin_s);
  assign rd_req    = rd_en & ~rd_cs_n;
  // a user read takes the staged word (look-ahead) or a stored word (registered)
  assign take      = mode_r.fwft ? (rd_req & valid) : (rd_req & ~ram_empty);
  assign load_fw   = ~ram_empty & (~valid | take);
  assign ram_pop   = mode_r.fwft ? load_fw : take;
  assign rptr_nx   = rptr + PW'(ram_pop);
  assign uptr_nx   = uptr + PW'(take);
  assign raddr     = rptr[AW-1:0];
  assign empty     = mode_r.fwft ? ~valid : ram_empty;

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) begin
      mode_r.fwft        <= fwft_sel;
      mode_r.async_flags <= async_sel;
      n_q                <= ofs_load ? pae_off : PW'(DEF_OFF);
    end
  end

  always_ff @(posedge rd_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      rptr      <= '0;
      uptr      <= '0;
      rgray     <= '0;
      ugray     <= '0;
      valid     <= 1'b0;
      rd_data   <= '0;
      pae_low_s <= 1'b1;
    end else begin
      rptr      <= rptr_nx;
      uptr      <= uptr_nx;
      rgray     <= PW'(bin2gray(32'(rptr_nx)));
      ugray     <= PW'(bin2gray(32'(uptr_nx)));
      if (ram_pop) rd_data <= ram_q;
      if (mode_r.fwft) valid <= load_fw | (valid & ~take);
      else             valid <= 1'b0;
      pae_low_s <= pae_hit(32'(wbin_s - uptr_nx), mode_r.fwft, 32'(n_q));
    end
  end
endmodule

// File: rtl/dcf_fifo36.sv
`timescale 1ns/1ps
module dcf_fifo36
  import dcf_pkg::*;
#(
  parameter int DW      = 36,
  parameter int AW      = 4,
  parameter int DEF_OFF = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          flag_async_sel,
  input  logic          ofs_load,
  input  logic [AW:0]   paf_off,
  input  logic [AW:0]   pae_off,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_cs_n,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          paf_n,
  output logic          pae_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ram_q;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wptr, wgray, rgray, ugray, uptr;
  logic [AW:0]   wsync_g, rsync_g, usync_g, m_q, n_q, occ_x;
  logic          wr_push, paf_low_s, pae_low_s, paf_low_x, pae_low_x;
  dcf_mode_t     mode_w, mode_r;

  dcf_wr_ctl #(.AW(AW), .DEF_OFF(DEF_OFF)) u_wr (
    .wr_clk(wr_clk), .mrst_n(mrst_n), .fwft_sel(fwft_sel), .async_sel(flag_async_sel),
    .ofs_load(ofs_load), .paf_off(paf_off), .wr_en(wr_en), .rsync_g(rsync_g),
    .usync_g(usync_g), .wr_push(wr_push), .waddr(waddr), .wptr(wptr), .wgray(wgray),
    .full(full), .paf_low_s(paf_low_s), .mode_w(mode_w), .m_q(m_q)
  );

  dcf_rd_ctl #(.AW(AW), .DW(DW), .DEF_OFF(DEF_OFF)) u_rd (
    .rd_clk(rd_clk), .mrst_n(mrst_n), .fwft_sel(fwft_sel), .async_sel(flag_async_sel),
    .ofs_load(ofs_load), .pae_off(pae_off), .rd_en(rd_en), .rd_cs_n(rd_cs_n),
    .wsync_g(wsync_g), .ram_q(ram_q), .raddr(raddr), .rgray(rgray), .ugray(ugray),
    .uptr(uptr), .rd_data(rd_data), .empty(empty), .pae_low_s(pae_low_s),
    .mode_r(mode_r), .n_q(n_q)
  );

  // write position into the read domain; read and user positions into the write domain
  dcf_sync2 #(.W(PW)) u_sync_w2r (.clk(rd_clk), .rst_n(mrst_n), .d(wgray), .q(wsync_g));
  dcf_sync2 #(.W(PW)) u_sync_r2w (.clk(wr_clk), .rst_n(mrst_n), .d(rgray), .q(rsync_g));
  dcf_sync2 #(.W(PW)) u_sync_u2w (.clk(wr_clk), .rst_n(mrst_n), .d(ugray), .q(usync_g));

  always_ff @(posedge wr_clk) begin
    if (wr_push) mem[waddr] <= wr_data;
  end
  assign ram_q = mem[raddr];

  // direct flag timing: live positions of both domains, no synchroniser
  assign occ_x     = wptr - uptr;
  assign paf_low_x = paf_hit(32'(occ_x), 32'(DEPTH), mode_w.fwft, 32'(m_q));
  assign pae_low_x = pae_hit(32'(occ_x), mode_r.fwft, 32'(n_q));

  assign paf_n = ~(mode_w.async_flags ? paf_low_x : paf_low_s);
  assign pae_n = ~(mode_r.async_flags ? pae_low_x : pae_low_s);
endmodule

// File: rtl/dcf_fifo36_chk.sv
`timescale 1ns/1ps
module dcf_fifo36_chk #(
  parameter int AW = 4
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        mrst_n,
  input logic        wr_en,
  input logic        full,
  input logic        rd_en,
  input logic        rd_cs_n,
  input logic        empty,
  input logic        pae_n,
  input logic [AW:0] wptr,
  input logic [AW:0] wgray,
  input logic [AW:0] uptr,
  input logic [AW:0] occ_x
);
  localparam int DEPTH = 1 << AW;

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!mrst_n) (full && wr_en) |=> $stable(wptr)); // R3
  AST_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!mrst_n) 32'(occ_x) <= 32'(DEPTH + 1)); // R3
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!mrst_n) $onehot0(wgray ^ $past(wgray))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!mrst_n) (empty && rd_en && !rd_cs_n) |=> $stable(uptr)); // R4
  AST_CS_GATE: assert property (@(posedge rd_clk) disable iff (!mrst_n) rd_cs_n |=> $stable(uptr)); // R4
  AST_RESET_STATE: assert property (@(posedge rd_clk) disable iff (!mrst_n) $rose(mrst_n) |-> (empty && !pae_n)); // R1
endmodule

bind dcf_fifo36 dcf_fifo36_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .wr_en(wr_en), .full(full),
  .rd_en(rd_en), .rd_cs_n(rd_cs_n), .empty(empty), .pae_n(pae_n), .wptr(wptr),
  .wgray(wgray), .uptr(uptr), .occ_x(occ_x)
);

// File: tb/dcf_fifo36_test.sv
`timescale 1ns/1ps
module dcf_fifo36_test;
  localparam int AW = 4;
  localparam int DW = 36;
  localparam int D  = 1 << AW;
  localparam int DEF_OFF = 2;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.5 rd_clk = ~rd_clk;

  logic          mrst_n = 1'b0, fwft_sel = 1'b0, flag_async_sel = 1'b0, ofs_load = 1'b0;
  logic [AW:0]   paf_off = '0, pae_off = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0, rd_cs_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full, empty, paf_n, pae_n;

  dcf_fifo36 #(.DW(DW), .AW(AW), .DEF_OFF(DEF_OFF)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .fwft_sel(fwft_sel),
    .flag_async_sel(flag_async_sel), .ofs_load(ofs_load), .paf_off(paf_off),
    .pae_off(pae_off), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_cs_n(rd_cs_n), .rd_data(rd_data), .full(full), .empty(empty),
    .paf_n(paf_n), .pae_n(pae_n)
  );

  int n_chk = 0, n_err = 0;
  int occ = 0, b_m = 0, b_n = 0;
  logic b_fwft = 1'b0;
  logic done = 1'b0;
  logic exp_acc = 1'b0;
  logic [DW-1:0] seen = '0, last_rd = '0, got, first_w;
  logic [DW-1:0] sb[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the driver has a read accepted
  always @(posedge rd_clk) begin
    if (exp_acc) begin
      if (!b_fwft) #1;
      got = b_fwft ? seen : rd_data;
      if (sb.size() == 0) check("R2 scoreboard underrun", 64'(1), 64'(0));
      else check("R2 word order", 64'(got), 64'(sb.pop_front()));
      last_rd = got;
    end
  end

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_data = d;
    wr_en   = 1'b1;
    if (!full) begin
      sb.push_back(d);
      occ++;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_word(input logic cs_hi);
    @(negedge rd_clk);
    rd_cs_n = cs_hi;
    rd_en   = 1'b1;
    if (!cs_hi && !empty) begin
      seen    = rd_data;
      exp_acc = 1'b1;
      occ--;
    end
    @(negedge rd_clk);
    rd_en   = 1'b0;
    rd_cs_n = 1'b0;
    exp_acc = 1'b0;
  endtask

  task automatic settle_chk(input string tp, input string te);
    repeat (8) @(negedge rd_clk);
    check("R3 full", 64'(full), 64'(occ == D + int'(b_fwft)));
    check("R4 empty", 64'(empty), 64'(occ == 0));
    check(tp, 64'(paf_n), 64'(!(occ >= D + int'(b_fwft) - b_m)));
    check(te, 64'(pae_n), 64'(!(occ <= b_n + int'(b_fwft))));
  endtask

  task automatic do_rst(input logic f, input logic a, input logic ld, input int m, input int n);
    mrst_n = 1'b0;
    fwft_sel = f; flag_async_sel = a; ofs_load = ld;
    paf_off = (AW+1)'(m); pae_off = (AW+1)'(n);
    wr_en = 1'b0; rd_en = 1'b0; rd_cs_n = 1'b0;
    repeat (4) @(negedge rd_clk);
    check("R1 empty in reset", 64'(empty), 64'(1));
    check("R1 full in reset", 64'(full), 64'(0));
    mrst_n = 1'b1;
    // R10 / R8: flip straps and offsets once reset is gone
    fwft_sel = !f; flag_async_sel = !a; ofs_load = !ld;
    paf_off = '0; pae_off = '0;
    b_fwft = f;
    b_m = ld ? m : DEF_OFF;
    b_n = ld ? n : DEF_OFF;
    occ = 0;
    sb.delete();
    @(negedge rd_clk);
    check("R1 empty", 64'(empty), 64'(1));
    check("R1 full", 64'(full), 64'(0));
    check("R1 pae_n", 64'(pae_n), 64'(0));
    check("R1 paf_n", 64'(paf_n), 64'(1));
  endtask

  initial begin
    // phase A: registered style, registered flags, offsets from pins
    do_rst(1'b0, 1'b0, 1'b1, 3, 2);
    for (int i = 1; i <= D; i++) begin
      wr_word(36'hA_0000_0000 | 36'(i));
      if (occ == b_n + 1) check("R9 registered pae_n lag", 64'(pae_n), 64'(0));
      settle_chk("R6 paf_n", "R7 pae_n");
      if (i == 1) check("R10 strap held (no look-ahead)", 64'(rd_data), 64'(0));
    end
    wr_word(36'hD_EAD0_0000);           // R3 write while full is dropped
    settle_chk("R6 paf_n", "R7 pae_n");
    while (occ > 0) begin
      rd_word(1'b0);
      if (occ == D - b_m - 1) check("R9 registered paf_n lag", 64'(paf_n), 64'(0));
      if (occ == D / 2) begin
        rd_word(1'b1);
        check("R4 chip select gates read", 64'(rd_data), 64'(last_rd));
      end
      settle_chk("R6 paf_n", "R7 pae_n");
    end
    rd_word(1'b0);                       // R4 read while empty
    check("R4 read on empty", 64'(rd_data), 64'(last_rd));
    settle_chk("R6 paf_n", "R7 pae_n");
    wr_word(36'h7_7777_0001);
    settle_chk("R6 paf_n", "R7 pae_n");
    rd_word(1'b0);
    settle_chk("R6 paf_n", "R7 pae_n");

    // phase B: look-ahead style, registered flags, default offsets
    do_rst(1'b1, 1'b0, 1'b0, 5, 5);
    first_w = 36'hB_1234_5678;
    wr_word(first_w);
    settle_chk("R8 paf_n default", "R8 pae_n default");
    check("R5 head word shown", 64'(rd_data), 64'(first_w));
    check("R5 empty low", 64'(empty), 64'(0));
    for (int i = 2; i <= D + 1; i++) begin
      wr_word(36'hB_0000_0000 | 36'(i));
      settle_chk("R8 paf_n default", "R8 pae_n default");
    end
    wr_word(36'hD_EAD0_0001);           // R3 write while full is dropped
    settle_chk("R8 paf_n default", "R8 pae_n default");
    while (occ > 0) begin
      rd_word(1'b0);
      settle_chk("R6 paf_n look-ahead", "R7 pae_n look-ahead");
    end

    // phase C: registered style, direct flag timing
    do_rst(1'b0, 1'b1, 1'b1, 1, 1);
    for (int i = 1; i <= D; i++) begin
      wr_word(36'hC_0000_0000 | 36'(i));
      if (occ == b_n + 1) check("R9 direct pae_n on write edge", 64'(pae_n), 64'(1));
      if (occ == D - b_m) check("R9 direct paf_n on write edge", 64'(paf_n), 64'(0));
      settle_chk("R6 paf_n", "R7 pae_n");
    end
    while (occ > 0) begin
      rd_word(1'b0);
      if (occ == D - b_m - 1) check("R9 direct paf_n on read edge", 64'(paf_n), 64'(1));
      if (occ == b_n) check("R9 direct pae_n on read edge", 64'(pae_n), 64'(0));
      settle_chk("R6 paf_n", "R7 pae_n");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule